// File: doc/BRIEF.md
# Three-Slot CAN Transmit Slot Allocator

This block sits between a frame producer and three transmit buffers of a CAN controller. When a frame is offered, it looks for a free buffer slot, trying the slots in a fixed order. It writes the frame's info word, identifier and two data words into that slot. In the same cycle it raises the command byte that tells the controller to send from that slot, either as a plain transmit or as a self-reception transmit.

The allocator keeps one busy flag per slot. A slot becomes busy when it is loaded and becomes free again when the controller pulses that slot's completion input. The free flags are shown on a status word at the bit positions the controller's software view expects. A request that finds every slot busy writes nothing and is reported as rejected. Sending on the bus and arbitration are handled elsewhere.

Top module: `can_tx_slot_alloc`

## Requirements
- R1: After reset, every slot is free: `status_o` reads 0x040404. `wr_en_o`, `cmd_o`, `cmd_vld_o`, `accept_o` and `reject_o` are all zero.
- R2: A request (`req_i` high at a rising edge) goes to the lowest-numbered free slot, trying slot 1, then slot 2, then slot 3. In the next cycle, `wr_en_o` is one-hot on that slot (bit 0 is slot 1) and `accept_o` is 1.
- R3: When neither `self_rx_i` nor `self_test_i` is set, the command byte is 0x21 for slot 1, 0x41 for slot 2 and 0x81 for slot 3.
- R4: When `self_rx_i` is set, the command byte is 0x30 for slot 1, 0x50 for slot 2 and 0x90 for slot 3.
- R5: When `self_test_i` is set, the self-reception command of R4 is issued whatever the value of `self_rx_i`.
- R6: The stored info word equals the offered info word ANDed with 0xC00F0000. This keeps the length code (bits 19:16), the remote flag (bit 30) and the extended-identifier flag (bit 31). A length code above 8 passes through unchanged. The identifier and both data words are passed through unchanged.
- R7: A request made while every slot is busy raises `reject_o` for one cycle. It writes no slot, issues no command and changes no free flag.
- R8: A slot's free flag clears in the cycle after the slot is loaded. It sets again in the cycle after that slot's `done_i` bit is high.
- R9: `cmd_vld_o` is high for exactly one cycle per accepted request, in the same cycle as `wr_en_o`. In every other cycle `cmd_o` is zero.
- R10: `status_o` holds the free flag of slot k (k = 0, 1, 2) at bit 8k+2 (bits 2, 10 and 18). All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Offer one frame this cycle |
| info_i | input | 32 | Frame info word (length, remote, extended flags) |
| id_i | input | 32 | Frame identifier |
| data_a_i | input | 32 | Data bytes 0 to 3 |
| data_b_i | input | 32 | Data bytes 4 to 7 |
| self_rx_i | input | 1 | Request self-reception for this frame |
| self_test_i | input | 1 | Self-test mode flag, forces self-reception |
| done_i | input | 3 | Per-slot completion pulse, frees the slot |
| wr_en_o | output | 3 | One-hot buffer write enable |
| wr_info_o | output | 32 | Masked info word to store |
| wr_id_o | output | 32 | Identifier to store |
| wr_da_o | output | 32 | Data word A to store |
| wr_db_o | output | 32 | Data word B to store |
| cmd_o | output | 8 | Command byte |
| cmd_vld_o | output | 1 | Command byte valid |
| accept_o | output | 1 | Request placed in a slot |
| reject_o | output | 1 | Request refused, no slot free |
| status_o | output | 24 | Free flags at bits 2, 10, 18 |

## Verification
The bench builds the block with its default parameters: three slots and 32-bit words. This is the only setting where the command bytes and the status bit positions are defined. With three slots, a short run of requests fills every slot and reaches the reject path. Completion pulses on chosen slots then free the slots in any order, which exercises the fixed priority under different free patterns. The info words in the vectors set bits both inside and outside the kept fields, and include a length code of 15.

// File: rtl/can_tx_alloc_pkg.sv
package can_tx_alloc_pkg;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned CMD_W         = 8;
  localparam logic [WORD_W-1:0] INFO_KEEP = 32'hC00F_0000;
  localparam int unsigned CMD_TX_BIT    = 0;
  localparam int unsigned CMD_SRR_BIT   = 4;
  localparam int unsigned CMD_SEL_BASE  = 5;
  localparam int unsigned STAT_STRIDE   = 8;
  localparam int unsigned STAT_FREE_OFS = 2;
endpackage

// File: rtl/cta_pick.sv
module cta_pick #(
  parameter int unsigned NUM_SLOTS = 3
) (
  input  logic [NUM_SLOTS-1:0] free_i,
  output logic [NUM_SLOTS-1:0] sel_o,
  output logic                 any_o
);
  // lower index wins
  logic [NUM_SLOTS:0] taken;
  assign taken[0] = 1'b0;
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_pri
    assign sel_o[k]   = free_i[k] & ~taken[k];
    assign taken[k+1] = taken[k] | free_i[k];
  end
  assign any_o = taken[NUM_SLOTS];
endmodule

// File: rtl/cta_cmd_enc.sv
module cta_cmd_enc
  import can_tx_alloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3
) (
  input  logic [NUM_SLOTS-1:0] sel_i,
  input  logic                 self_rx_i,
  input  logic                 self_test_i,
  output logic [CMD_W-1:0]     cmd_o
);
  logic srr;
  assign srr = self_rx_i | self_test_i;

  always_comb begin
    cmd_o = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (sel_i[k]) cmd_o[CMD_SEL_BASE+k] = 1'b1;
    end
    if (|sel_i) begin
      cmd_o[CMD_TX_BIT]  = ~srr;
      cmd_o[CMD_SRR_BIT] = srr;
    end
  end
endmodule

// File: rtl/cta_free_track.sv
module cta_free_track #(
  parameter int unsigned NUM_SLOTS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] load_i,
  input  logic [NUM_SLOTS-1:0] done_i,
  output logic [NUM_SLOTS-1:0] free_o
);
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        free_o[k] <= 1'b1;
      else if (load_i[k]) free_o[k] <= 1'b0;
      else if (done_i[k]) free_o[k] <= 1'b1;
    end

    a_r8_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i[k] |=> !free_o[k]);
    a_r8_done_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i[k] && !load_i[k]) |=> free_o[k]);
  end
endmodule

// File: rtl/can_tx_slot_alloc.sv
module can_tx_slot_alloc
  import can_tx_alloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3,
  localparam int unsigned STAT_W   = NUM_SLOTS * STAT_STRIDE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [WORD_W-1:0]    info_i,
  input  logic [WORD_W-1:0]    id_i,
  input  logic [WORD_W-1:0]    data_a_i,
  input  logic [WORD_W-1:0]    data_b_i,
  input  logic                 self_rx_i,
  input  logic                 self_test_i,
  input  logic [NUM_SLOTS-1:0] done_i,
  output logic [NUM_SLOTS-1:0] wr_en_o,
  output logic [WORD_W-1:0]    wr_info_o,
  output logic [WORD_W-1:0]    wr_id_o,
  output logic [WORD_W-1:0]    wr_da_o,
  output logic [WORD_W-1:0]    wr_db_o,
  output logic [CMD_W-1:0]     cmd_o,
  output logic                 cmd_vld_o,
  output logic                 accept_o,
  output logic                 reject_o,
  output logic [STAT_W-1:0]    status_o
);
  logic [NUM_SLOTS-1:0] free, sel, load;
  logic                 any_free, take;
  logic [CMD_W-1:0]     cmd_d;

  cta_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .free_i(free), .sel_o(sel), .any_o(any_free)
  );

  assign take = req_i & any_free;
  assign load = take ? sel : '0;

  cta_cmd_enc #(.NUM_SLOTS(NUM_SLOTS)) u_cmd (
    .sel_i(load), .self_rx_i(self_rx_i), .self_test_i(self_test_i), .cmd_o(cmd_d)
  );

  cta_free_track #(.NUM_SLOTS(NUM_SLOTS)) u_free (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .done_i(done_i), .free_o(free)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= '0;
      cmd_o     <= '0;
      cmd_vld_o <= 1'b0;
      accept_o  <= 1'b0;
      reject_o  <= 1'b0;
      wr_info_o <= '0;
      wr_id_o   <= '0;
      wr_da_o   <= '0;
      wr_db_o   <= '0;
    end else begin
      wr_en_o   <= load;
      cmd_o     <= cmd_d;
      cmd_vld_o <= take;
      accept_o  <= take;
      reject_o  <= req_i & ~any_free;
      if (take) begin
        wr_info_o <= info_i & INFO_KEEP;
        wr_id_o   <= id_i;
        wr_da_o   <= data_a_i;
        wr_db_o   <= data_b_i;
      end
    end
  end

  always_comb begin
    status_o = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      status_o[k*STAT_STRIDE+STAT_FREE_OFS] = free[k];
    end
  end

  a_r2_onehot_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  a_r2_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && free[0]) |=> wr_en_o[0]);
  a_r7_reject_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (wr_en_o == '0 && !cmd_vld_o && !accept_o));
  a_r7_full_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && free == '0 && done_i == '0) |=> (free == '0));
  a_r6_info_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> ((wr_info_o & ~INFO_KEEP) == '0));
  a_r5_self_test_srr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && self_test_i && any_free) |=> (cmd_o[CMD_SRR_BIT] && !cmd_o[CMD_TX_BIT]));
  a_r9_cmd_with_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> (wr_en_o != '0 && accept_o));
  a_r9_cmd_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_o |-> (cmd_o == '0));
endmodule

// File: tb/can_tx_slot_alloc_tb_top.sv
module can_tx_slot_alloc_tb_top;
  typedef struct packed {
    logic [2:0]  done;
    logic        srx;
    logic        stst;
    logic [31:0] info;
    logic [2:0]  exp_wr;
    logic [7:0]  exp_cmd;
    logic        exp_acc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 1'b0, 32'hFFFF_FFFF, 3'b001, 8'h21, 1'b1},
    '{3'b000, 1'b1, 1'b0, 32'h4008_ABCD, 3'b010, 8'h50, 1'b1},
    '{3'b000, 1'b0, 1'b1, 32'h8005_12EF, 3'b100, 8'h90, 1'b1},
    '{3'b000, 1'b0, 1'b0, 32'hFFFF_FFFF, 3'b000, 8'h00, 1'b0},
    '{3'b010, 1'b0, 1'b0, 32'h000F_0000, 3'b010, 8'h41, 1'b1},
    '{3'b101, 1'b0, 1'b1, 32'h3FF0_FFFF, 3'b001, 8'h30, 1'b1},
    '{3'b000, 1'b1, 1'b1, 32'hC003_0000, 3'b100, 8'h90, 1'b1},
    '{3'b000, 1'b1, 1'b0, 32'h0001_0000, 3'b000, 8'h00, 1'b0},
    '{3'b111, 1'b0, 1'b0, 32'h1234_5678, 3'b001, 8'h21, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, srx = 1'b0, stst = 1'b0;
  logic [31:0] info = '0, id = '0, da = '0, db = '0;
  logic [2:0]  done = '0;
  logic [2:0]  wr_en;
  logic [31:0] wr_info, wr_id, wr_da, wr_db;
  logic [7:0]  cmd;
  logic        cmd_vld, acc, rej;
  logic [23:0] status;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  can_tx_slot_alloc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .info_i(info), .id_i(id),
    .data_a_i(da), .data_b_i(db), .self_rx_i(srx), .self_test_i(stst),
    .done_i(done), .wr_en_o(wr_en), .wr_info_o(wr_info), .wr_id_o(wr_id),
    .wr_da_o(wr_da), .wr_db_o(wr_db), .cmd_o(cmd), .cmd_vld_o(cmd_vld),
    .accept_o(acc), .reject_o(rej), .status_o(status)
  );

  function automatic logic [23:0] stat_of(logic [2:0] f);
    logic [23:0] s = '0;
    for (int k = 0; k < 3; k++) s[k*8+2] = f[k];
    return s;
  endfunction

  task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req_tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] efree;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", 64'(status), 64'h040404);
    chk("R1 wr_en", 64'(wr_en), 0);
    chk("R1 cmd", 64'({cmd_vld, cmd, acc, rej}), 0);
    rst_n = 1'b1;
    efree = 3'b111;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      done = VECS[i].done;
      efree |= VECS[i].done;
      @(negedge clk);
      done = '0;
      req  = 1'b1;
      info = VECS[i].info;
      srx  = VECS[i].srx;
      stst = VECS[i].stst;
      id   = 32'h1000_0000 + 32'(i);
      da   = 32'hA0A0_0000 + 32'(i);
      db   = 32'hB0B0_0000 + 32'(i);
      @(negedge clk);
      req = 1'b0;
      efree &= ~VECS[i].exp_wr;
      // R2 priority, R3/R4/R5 command, R7 reject
      chk("R2 wr_en", 64'(wr_en), 64'(VECS[i].exp_wr));
      chk("R3 R4 R5 cmd", 64'(cmd), 64'(VECS[i].exp_cmd));
      chk("R2 accept", 64'(acc), 64'(VECS[i].exp_acc));
      chk("R7 reject", 64'(rej), 64'(!VECS[i].exp_acc));
      chk("R9 cmd_vld", 64'(cmd_vld), 64'(VECS[i].exp_acc));
      chk("R8 R10 status", 64'(status), 64'(stat_of(efree)));
      if (VECS[i].exp_acc) begin
        chk("R6 info", 64'(wr_info), 64'(VECS[i].info & 32'hC00F_0000));
        chk("R6 id/data", {wr_id, wr_da ^ wr_db},
            {id, (32'hA0A0_0000 + 32'(i)) ^ (32'hB0B0_0000 + 32'(i))});
      end
      @(negedge clk);
      chk("R9 one cycle", 64'({cmd_vld, cmd, wr_en}), 0);
    end

    // R6 length code 15 passes unchanged (vector 4 style, directed)
    @(negedge clk);
    done = 3'b010;
    @(negedge clk);
    done = '0; req = 1'b1; info = 32'hC00F_FFFF; srx = 1'b0; stst = 1'b0;
    @(negedge clk);
    req = 1'b0;
    chk("R6 len15", 64'(wr_info[19:16]), 64'hF);
    chk("R6 flags", 64'(wr_info[31:30]), 64'h3);
    chk("R3 slot2 cmd", 64'(cmd), 64'h41);

    // R8 done frees slot 3 alone
    @(negedge clk);
    done = 3'b100;
    @(negedge clk);
    done = '0;
    chk("R8 R10 free3", 64'(status), 64'h040000);

    // R1 reset mid-run frees all
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rereset", 64'(status), 64'h040404);
    chk("R1 rereset outs", 64'({cmd_vld, acc, rej, wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule